// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a simple request/response host port and a 16-bit asynchronous static RAM. It turns each accepted request into one correctly timed read or write cycle on the memory pins: address, chip enable, output enable, write enable, upper and lower byte enables, and the split data bus (output value, driver enable, input value). Every interval the memory needs is a whole number of clock cycles. Each interval is found by rounding up a nanosecond figure, picked by a speed-grade parameter, divided by the clock-period parameter.

After reset the controller waits out a power-up lockout of at least 1 ms before it accepts any request. It then takes requests through a valid/ready handshake. A read returns its word with a single-cycle valid pulse. A write uses a per-byte mask and is timed by write enable, with output enable held high and the data driver on only while no other driver can be active. The state machine has six states: POWERUP (lockout), IDLE (ready to accept), RD_TURN (one bus-turnaround cycle before a read that follows a write), RD_ACCESS (read strobes active, data captured on the last cycle), WR_PULSE (write strobe low) and WR_RECOVER (write strobe released, rest of the write cycle time). The transitions are: POWERUP→IDLE when the lockout ends; IDLE→WR_PULSE on an accepted write; IDLE→RD_TURN on an accepted read after a write; IDLE→RD_ACCESS on any other accepted read; RD_TURN→RD_ACCESS after one cycle; RD_ACCESS→IDLE, WR_PULSE→WR_RECOVER and WR_RECOVER→IDLE each when its cycle count runs out.

Top module: `sram_ctl`

## Requirements
- R1: After reset, `req_ready` stays low and chip enable, output enable, write enable and both byte enables stay high, with the data driver off, for at least ceil(PWRUP_NS/CLK_NS) cycles (1 ms by default). No memory access starts inside that window.
- R2: A read drives chip enable, output enable and both byte enables low with the address. It captures `sram_dq_i` on the last of RD cycles, where RD is the largest of the rounded-up address-to-data, read-cycle and output-enable-to-data times. `rsp_valid` is then high for exactly one cycle, RD cycles after the accepting edge (sampled at the next falling edge this gives a count of RD+1).
- R3: A write holds chip enable and write enable low together for WP cycles, where WP is the largest of the rounded-up write-pulse, byte-enable-to-write-end and data-setup times. Both strobes rise on the same edge, which ends the write.
- R4: While write enable is low, and in the cycle in which it rises, the address and the write data stay unchanged. The byte enables stay unchanged while write enable is low.
- R5: `req_bmask` bit 0 selects the low byte and bit 1 the high byte, and 1 means write that byte. `sram_lb_n`/`sram_ub_n` are the inverted mask bits during the write pulse, and a byte with a mask bit of 0 keeps its earlier content.
- R6: From the cycle in which a write starts to the next cycle in which chip enable falls, at least ceil(tWC/CLK_NS) cycles pass. The recovery state holds all strobes high for max(1, WC−WP) cycles.
- R7: Output enable is high throughout a write. The data driver is on only when output enable is high in that cycle and was high in the one before. The driver is on for the whole write pulse and turns off in the cycle in which write enable rises.
- R8: `req_ready` is high only in IDLE. A request is accepted on an edge where `req_valid` and `req_ready` are both high, and chip enable goes low in the very next cycle. Back-to-back writes are therefore accepted WP + max(1, WC−WP) + 1 cycles apart.
- R9: A read accepted right after a write spends one extra cycle with chip enable low and output enable high before output enable falls. This adds one cycle to its latency.
- R10: Each nanosecond figure becomes max(1, ceil(ns/CLK_NS)) cycles. `GRADE` 0, 1 and 2 choose the fastest, middle and slowest timing sets. At the defaults (10 ns clock, grade 0) this gives RD=2, WP=1, WC=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Active-low reset; the power-up lockout counts from its release |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte write mask, bit 1 = high byte, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read data |
| sram_addr | output | AW | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_ub_n | output | 1 | High byte enable, active low |
| sram_lb_n | output | 1 | Low byte enable, active low |
| sram_dq_o | output | 16 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Data driver enable |
| sram_dq_i | input | 16 | Data read from the memory bus |

## Verification
The assertions check on every cycle that the strobes obey the lockout, that write enable never goes low without chip enable and never with output enable low, and that the data driver never overlaps output enable. They also check that address, data and byte enables hold still across the write pulse and that every measured write pulse and write cycle meets its nanosecond minimum. Only the bench scenarios can show that the right bytes land in memory and that read data arrives after the real access delay. These rely on a behavioural memory whose output stays invalid until the address and output-enable delays have elapsed. The scenarios also show the exact read latencies with and without a preceding write and the spacing of back-to-back requests.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    localparam int SRAM_DW = 16;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_IDLE,
        ST_RD_TURN,
        ST_RD_ACCESS,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } ctl_state_e;

    // Round a nanosecond figure up to whole clocks, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Per-grade nanosecond figures: grade 0 fastest, 2 slowest.
    function automatic int t_addr_data_ns(input int g);
        return (g == 0) ? 12 : (g == 1) ? 15 : 17;
    endfunction
    function automatic int t_oe_data_ns(input int g);
        return (g == 0) ? 6 : 7;
    endfunction
    function automatic int t_we_pulse_ns(input int g);
        return (g == 0) ? 10 : (g == 1) ? 12 : 14;
    endfunction
    function automatic int t_wr_cycle_ns(input int g);
        return (g == 0) ? 12 : (g == 1) ? 15 : 17;
    endfunction
    function automatic int t_data_setup_ns(input int g);
        return (g == 0) ? 7 : 8;
    endfunction
    function automatic int t_be_end_ns(input int g);
        return (g == 0) ? 10 : 12;
    endfunction

endpackage

// File: rtl/sram_pwrup_timer.sv
`timescale 1ns/1ps
module sram_pwrup_timer #(
    parameter int CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else if (!done) begin
            if (cnt_q == CW'(CYCLES - 1)) begin
                done <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sram_cycle_cnt.sv
`timescale 1ns/1ps
module sram_cycle_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int GRADE    = 0,
    parameter int AW       = 18,
    parameter int PWRUP_NS = 1000000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [AW-1:0]       req_addr,
    input  logic [SRAM_DW-1:0]  req_wdata,
    input  logic [1:0]          req_bmask,
    output logic                rsp_valid,
    output logic [SRAM_DW-1:0]  rsp_rdata,
    output logic [AW-1:0]       sram_addr,
    output logic                sram_ce_n,
    output logic                sram_oe_n,
    output logic                sram_we_n,
    output logic                sram_ub_n,
    output logic                sram_lb_n,
    output logic [SRAM_DW-1:0]  sram_dq_o,
    output logic                sram_dq_oe,
    input  logic [SRAM_DW-1:0]  sram_dq_i
);
    // Cycle counts derived from the grade table and the clock period.
    localparam int AA_C   = ns_to_cyc(t_addr_data_ns(GRADE), CLK_NS);
    localparam int RC_C   = ns_to_cyc(t_wr_cycle_ns(GRADE), CLK_NS);
    localparam int DOE_C  = ns_to_cyc(t_oe_data_ns(GRADE), CLK_NS);
    localparam int RD_C   = max3(AA_C, RC_C, DOE_C);
    localparam int WP_C   = max3(ns_to_cyc(t_we_pulse_ns(GRADE), CLK_NS),
                                 ns_to_cyc(t_be_end_ns(GRADE), CLK_NS),
                                 ns_to_cyc(t_data_setup_ns(GRADE), CLK_NS));
    localparam int WC_C   = ns_to_cyc(t_wr_cycle_ns(GRADE), CLK_NS);
    localparam int REC_C  = (WC_C > WP_C) ? (WC_C - WP_C) : 1;
    localparam int PWR_C  = ns_to_cyc(PWRUP_NS, CLK_NS);
    localparam int CNT_W  = $clog2(max3(RD_C, WP_C, REC_C) + 1);

    ctl_state_e          state_q, state_d;
    logic                cnt_load, cnt_done, pwr_done;
    logic [CNT_W-1:0]    cnt_val;
    logic                accept;
    logic                last_wr_q;
    logic [AW-1:0]       addr_q;
    logic [SRAM_DW-1:0]  wdata_q, rdata_q;
    logic [1:0]          mask_q, mask_d;
    logic                rvalid_q;

    sram_pwrup_timer #(.CYCLES(PWR_C)) u_pwrup (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (pwr_done)
    );

    sram_cycle_cnt #(.CW(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign mask_d    = accept ? req_bmask : mask_q;

    // Next-state and counter-load decode.
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_POWERUP: begin
                if (pwr_done) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        state_d  = ST_WR_PULSE;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(WP_C - 1);
                    end else if (last_wr_q) begin
                        state_d  = ST_RD_TURN;
                    end else begin
                        state_d  = ST_RD_ACCESS;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(RD_C - 1);
                    end
                end
            end
            ST_RD_TURN: begin
                state_d  = ST_RD_ACCESS;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(RD_C - 1);
            end
            ST_RD_ACCESS: begin
                if (cnt_done) state_d = ST_IDLE;
            end
            ST_WR_PULSE: begin
                if (cnt_done) begin
                    state_d  = ST_WR_RECOVER;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(REC_C - 1);
                end
            end
            ST_WR_RECOVER: begin
                if (cnt_done) state_d = ST_IDLE;
            end
            default: state_d = ST_POWERUP;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_POWERUP;
        else        state_q <= state_d;
    end

    // Request capture and read-data return.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            mask_q    <= '0;
            last_wr_q <= 1'b0;
            rdata_q   <= '0;
            rvalid_q  <= 1'b0;
        end else begin
            if (accept) begin
                addr_q    <= req_addr;
                wdata_q   <= req_wdata;
                mask_q    <= req_bmask;
                last_wr_q <= req_write;
            end
            rvalid_q <= (state_q == ST_RD_ACCESS) && cnt_done;
            if ((state_q == ST_RD_ACCESS) && cnt_done) rdata_q <= sram_dq_i;
        end
    end

    // Registered pin outputs, decoded from the state being entered.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sram_ce_n  <= 1'b1;
            sram_oe_n  <= 1'b1;
            sram_we_n  <= 1'b1;
            sram_ub_n  <= 1'b1;
            sram_lb_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
        end else begin
            sram_ce_n  <= !((state_d == ST_RD_TURN) || (state_d == ST_RD_ACCESS) ||
                            (state_d == ST_WR_PULSE));
            sram_oe_n  <= !(state_d == ST_RD_ACCESS);
            sram_we_n  <= !(state_d == ST_WR_PULSE);
            sram_dq_oe <= (state_d == ST_WR_PULSE) && sram_oe_n;
            unique case (state_d)
                ST_RD_TURN, ST_RD_ACCESS: begin
                    sram_ub_n <= 1'b0;
                    sram_lb_n <= 1'b0;
                end
                ST_WR_PULSE: begin
                    sram_ub_n <= !mask_d[1];
                    sram_lb_n <= !mask_d[0];
                end
                default: begin
                    sram_ub_n <= 1'b1;
                    sram_lb_n <= 1'b1;
                end
            endcase
        end
    end

    assign sram_addr = addr_q;
    assign sram_dq_o = wdata_q;
    assign rsp_valid = rvalid_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int GRADE    = 0,
    parameter int AW       = 18,
    parameter int PWRUP_NS = 1000000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic [AW-1:0]      sram_addr,
    input logic               sram_ce_n,
    input logic               sram_oe_n,
    input logic               sram_we_n,
    input logic               sram_ub_n,
    input logic               sram_lb_n,
    input logic [SRAM_DW-1:0] sram_dq_o,
    input logic               sram_dq_oe
);
    localparam int PWR_C = ns_to_cyc(PWRUP_NS, CLK_NS);

    logic [31:0] up_cnt;
    logic [15:0] lo_cnt, since_wr;
    logic        we_q, wr_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_cnt   <= '0;
            lo_cnt   <= '0;
            since_wr <= '0;
            we_q     <= 1'b1;
            wr_seen  <= 1'b0;
        end else begin
            we_q   <= sram_we_n;
            lo_cnt <= sram_we_n ? 16'd0 : lo_cnt + 16'd1;
            if (up_cnt < 32'(PWR_C)) up_cnt <= up_cnt + 32'd1;
            if (we_q && !sram_we_n) begin
                since_wr <= 16'd1;
                wr_seen  <= 1'b1;
            end else if (since_wr != 16'hFFFF) begin
                since_wr <= since_wr + 16'd1;
            end
        end
    end

    assert_ready_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (up_cnt == 32'(PWR_C)));
    assert_no_early_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> (up_cnt == 32'(PWR_C)));
    assert_read_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n && !sram_dq_oe));
    assert_rsp_in_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!sram_oe_n));
    assert_we_needs_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_ce_n);
    assert_end_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> sram_ce_n);
    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> ((int'(lo_cnt) * CLK_NS >= t_we_pulse_ns(GRADE)) &&
                              (int'(lo_cnt) * CLK_NS >= t_be_end_ns(GRADE)) &&
                              (int'(lo_cnt) * CLK_NS >= t_data_setup_ns(GRADE))));
    assert_pulse_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && $past(!sram_we_n)) |->
            ($stable(sram_addr) && $stable(sram_dq_o) && $stable(sram_ub_n) && $stable(sram_lb_n)));
    assert_end_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_dq_o)));
    assert_wr_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sram_ce_n) && wr_seen) |-> (int'(since_wr) * CLK_NS >= t_wr_cycle_ns(GRADE)));
    assert_drv_after_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (sram_oe_n && $past(sram_oe_n)));
    assert_drv_in_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_oe_n && sram_dq_oe));
    assert_drv_off_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> !sram_dq_oe);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_we_n));
    assert_start_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !sram_ce_n);

endmodule

bind sram_ctl sram_ctl_chk #(
    .CLK_NS   (CLK_NS),
    .GRADE    (GRADE),
    .AW       (AW),
    .PWRUP_NS (PWRUP_NS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_ub_n  (sram_ub_n),
    .sram_lb_n  (sram_lb_n),
    .sram_dq_o  (sram_dq_o),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/test_sram_ctl.sv
`timescale 1ns/1ps
module test_sram_ctl;
    localparam int AW      = 18;
    localparam int CLK     = 10;
    // Grade-0 figures in ns, and the cycle counts the requirements give for them.
    localparam int AA_NS   = 12;
    localparam int DOE_NS  = 6;
    localparam int PWE_NS  = 10;
    localparam int WC_NS   = 12;
    localparam int RD_CYC  = 2;
    localparam int WP_CYC  = 1;
    localparam int REC_CYC = 1;
    localparam longint PWR_NS = 1000000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_bmask = '0;
    logic req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [AW-1:0] sram_addr;
    logic sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe;
    logic [15:0] sram_dq_o;
    logic [15:0] sram_dq_i = 16'hBAD0;

    int checks = 0, fails = 0, viol = 0;
    int cyc = 0;
    bit finished = 1'b0;
    longint t_rst = 0, t_addr = 0, t_oe = 0;

    sram_ctl #(.CLK_NS(CLK), .GRADE(0), .AW(AW), .PWRUP_NS(1000000)) i_sram_ctl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
        .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- behavioural memory ----------------
    logic [15:0] mem [int unsigned];
    bit          wr_act_q = 1'b0;
    logic [AW-1:0] lat_a;
    logic [15:0] lat_d;
    logic        lat_ub, lat_lb;

    always @(sram_addr) t_addr = $time;
    always @(negedge sram_oe_n) t_oe = $time;

    always @(negedge clk) begin
        logic [15:0] w;
        if (rst_n) begin
            if (!sram_ce_n && ($time - t_rst < PWR_NS)) viol++;
            if (sram_dq_oe && !sram_oe_n) viol++;
            if (!sram_ce_n && !sram_oe_n) begin
                w = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 16'h0000;
                sram_dq_i <= (($time - t_addr >= AA_NS) && ($time - t_oe >= DOE_NS)) ? w : 16'hBAD0;
            end else begin
                sram_dq_i <= 16'hBAD0;
            end
            if (!sram_ce_n && !sram_we_n) begin
                if (!sram_dq_oe) viol++;
                lat_a = sram_addr; lat_d = sram_dq_o;
                lat_ub = !sram_ub_n; lat_lb = !sram_lb_n;
                wr_act_q = 1'b1;
            end else if (wr_act_q) begin
                w = mem.exists(int'(lat_a)) ? mem[int'(lat_a)] : 16'h0000;
                if (lat_ub) w[15:8] = lat_d[15:8];
                if (lat_lb) w[7:0]  = lat_d[7:0];
                mem[int'(lat_a)] = w;
                wr_act_q = 1'b0;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    int acc_cyc;
    task automatic issue(input bit w, input logic [AW-1:0] a,
                         input logic [15:0] d, input logic [1:0] m);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_bmask = m;
        @(negedge clk);
        acc_cyc = cyc;
        req_valid = 1'b0;
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input logic [15:0] exp,
                            input int exp_lat, input string req);
        int lat;
        issue(1'b0, a, 16'h0, 2'b00);
        lat = 1;
        while (!rsp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(rsp_rdata == exp, req, "read data", rsp_rdata, exp);
        chk(lat == exp_lat, req, "read latency", lat, exp_lat);
        @(negedge clk);
        chk(!rsp_valid, "R2", "rsp_valid single cycle", rsp_valid, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(!req_ready, "R1", "ready at reset", req_ready, 0);
        chk(sram_ce_n && sram_oe_n && sram_we_n, "R1", "strobes high",
            {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
        chk(sram_ub_n && sram_lb_n && !sram_dq_oe, "R1", "byte en/driver idle",
            {sram_ub_n, sram_lb_n, sram_dq_oe}, 3'b110);
        chk(!rsp_valid, "R1", "no response", rsp_valid, 0);
    endtask

    task automatic t_powerup;
        longint t_rdy;
        #(PWR_NS - 100);
        chk(!req_ready, "R1", "ready before 1 ms", req_ready, 0);
        while (!req_ready) @(negedge clk);
        t_rdy = $time - t_rst;
        chk(t_rdy >= PWR_NS && t_rdy <= PWR_NS + 50, "R1", "lockout length ns", t_rdy, PWR_NS);
    endtask

    task automatic t_word;
        issue(1'b1, 18'h00010, 16'hA5C3, 2'b11);
        read_chk(18'h00010, 16'hA5C3, RD_CYC + 2, "R9");   // turnaround after write
        read_chk(18'h00010, 16'hA5C3, RD_CYC + 1, "R2");   // read after read
    endtask

    task automatic t_bytes;
        issue(1'b1, 18'h00020, 16'h1234, 2'b11);
        issue(1'b1, 18'h00020, 16'hABCD, 2'b01);           // low byte only
        read_chk(18'h00020, 16'h12CD, RD_CYC + 2, "R5");
        issue(1'b1, 18'h00020, 16'hEF77, 2'b10);           // high byte only
        read_chk(18'h00020, 16'hEFCD, RD_CYC + 2, "R5");
        issue(1'b1, 18'h00020, 16'h5555, 2'b00);           // no byte
        read_chk(18'h00020, 16'hEFCD, RD_CYC + 2, "R5");
    endtask

    task automatic t_wr_timing;
        int lo, n;
        bit ce_ok, oe_ok, drv_ok, be_ok, ended;
        lo = 0; n = 0; ce_ok = 1; oe_ok = 1; drv_ok = 1; be_ok = 1; ended = 0;
        issue(1'b1, 18'h00030, 16'h0F0F, 2'b10);
        while (!req_ready && n < 20) begin
            n++;
            if (!sram_we_n) begin
                lo++;
                if (sram_ce_n) ce_ok = 0;
                if (!sram_oe_n) oe_ok = 0;
                if (!sram_dq_oe) drv_ok = 0;
                if (sram_ub_n || !sram_lb_n) be_ok = 0;
            end else if (lo > 0 && !ended) begin
                ended = 1;
                if (!sram_ce_n) ce_ok = 0;
                if (sram_dq_oe) drv_ok = 0;
            end
            @(negedge clk);
        end
        chk(lo == WP_CYC && lo * CLK >= PWE_NS, "R3", "write pulse cycles", lo, WP_CYC);
        chk(ce_ok, "R3", "ce with we, rise together", ce_ok, 1);
        chk(oe_ok, "R7", "oe high in write", oe_ok, 1);
        chk(drv_ok, "R7", "driver on in pulse, off at end", drv_ok, 1);
        chk(be_ok, "R5", "byte enables = ~mask", be_ok, 1);
        chk(n == WP_CYC + REC_CYC && (n + 1) * CLK >= WC_NS, "R6", "write occupancy",
            n, WP_CYC + REC_CYC);
    endtask

    task automatic t_b2b;
        int a0;
        issue(1'b1, 18'h00100, 16'h1111, 2'b11);
        a0 = acc_cyc;
        issue(1'b1, 18'h00101, 16'h2222, 2'b11);
        chk(acc_cyc - a0 == WP_CYC + REC_CYC + 1, "R8", "write spacing", acc_cyc - a0,
            WP_CYC + REC_CYC + 1);
        a0 = acc_cyc;
        issue(1'b1, 18'h3FFFF, 16'h3333, 2'b11);
        chk(acc_cyc - a0 == WP_CYC + REC_CYC + 1, "R8", "write spacing 2", acc_cyc - a0,
            WP_CYC + REC_CYC + 1);
        read_chk(18'h00100, 16'h1111, RD_CYC + 2, "R8");
        read_chk(18'h00101, 16'h2222, RD_CYC + 1, "R10");
        read_chk(18'h3FFFF, 16'h3333, RD_CYC + 1, "R10");
    endtask

    initial begin
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_rst = $time;
        t_powerup();
        t_word();
        t_bytes();
        t_wr_timing();
        t_b2b();
        chk(viol == 0, "R1", "memory model violations (lockout, R7 contention)", viol, 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1900000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule